// File: doc/BRIEF.md
# Precision Time Counter with Command Engine

This block keeps a running time value made of a 48-bit seconds count, a 32-bit nanoseconds count and a 32-bit fraction in units of 2^-32 ns. On every clock it adds a programmable step to that value. The step is a whole number of nanoseconds plus a signed fractional part. A separate signed trim is added on top of the fractional part, so software can tune the rate without touching the nominal step.

Software reaches the block through a small word-addressed register port. Every register carries 16 bits of data. A three-bit command field picks one of five actions: load a new time, take the staged fraction as the rate trim, add the staged time, subtract the staged time, or snapshot the running time into one of two capture slots. A command runs when software writes the command register with its fire bit set. It also runs on a rising edge of the event input. That input cannot be masked, so software parks the command field at its no-operation code when idle. A run bit acts as a soft reset: while it is clear the time does not advance, but commands still act on it.

Top module: `ptp_tod_unit`

## Requirements
- R1: After reset the whole-ns step reads 3 and the fractional step, the trim, the run bit and the status word read 0. The command register reads 0x001C (command code 7).
- R2: While the run bit (bit 0 at word address 0) is 0, the time does not change except through commands. While it is 1, the time gains step_ns + (step_frac + trim)·2^-32 ns on every clock. step_frac and trim are signed 32-bit values.
- R3: When nanoseconds reach 1,000,000,000 or more after a step or an add, 1,000,000,000 is removed and seconds increase by one. Nanoseconds always stay below 1,000,000,000.
- R4: The command register is word address 1. Bits 4:2 hold the code: 0 load, 1 trim, 2 add, 3 subtract, 4 snapshot, 7 no-operation. A write with bit 0 set runs the code carried in that same write, once. Bit 0 always reads 0. Bit 8 is a stored phase-enable flag. A write with bit 0 clear only selects a code.
- R5: Load copies the staged seconds, nanoseconds and fraction into the running time.
- R6: Add and subtract apply the staged time to the running time with carry or borrow between the fraction, the nanoseconds and the seconds. A borrow out of nanoseconds takes one second.
- R7: Trim copies the staged fraction into the signed rate trim used by R2.
- R8: A snapshot goes to slot 0 when slot 0 is not valid, otherwise to slot 1, overwriting it. Status (word 26) bit 0 marks slot 0 valid and bit 1 marks slot 1 valid. Reading the status word clears both bits.
- R9: A rising edge on ev_in runs the stored code once, exactly as a fire-bit write would. Holding ev_in high does not repeat the action, and code 7 changes nothing.
- R10: Word map: 0 run, 1 command, 2 step_ns, 3/4 step fraction high/low, 5..11 staged time, 12..18 slot 0, 19..25 slot 1, 26 status. Each time block is ordered seconds high/mid/low, nanoseconds high/low, fraction high/low. Reads return the value in bits 15:0 with bits 31:16 zero, and writes ignore bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on word 26) |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data, bits 15:0 used |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ev_in | input | 1 | Unmaskable external command trigger |

## Verification
Add and subtract are swept over a grid of running times and offsets at the edges of the nanosecond and fraction ranges. That grid separates the carry and borrow paths, including the cases where a fraction borrow ripples into nanoseconds and seconds. The advance is swept over whole steps, positive and negative fractional steps and extreme trims, always starting just below a second boundary. A wrong sign extension or a missed rollover therefore gives a different snapshot. Three successive snapshots show the slot order. Events with a held level, with code 7 and with a load code separate edge detection from level detection and from the stored code.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    localparam int SEC_W  = 48;
    localparam int NS_W   = 32;
    localparam int FR_W   = 32;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 6;
    localparam int PIECES = 7;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [FR_W-1:0]  frac;
    } tod_t;

    localparam logic [2:0] FN_LOAD = 3'd0;
    localparam logic [2:0] FN_TRIM = 3'd1;
    localparam logic [2:0] FN_ADD  = 3'd2;
    localparam logic [2:0] FN_SUB  = 3'd3;
    localparam logic [2:0] FN_SNAP = 3'd4;
    localparam logic [2:0] FN_IDLE = 3'd7;

    localparam logic [ADDR_W-1:0] A_CTRL    = 6'd0;
    localparam logic [ADDR_W-1:0] A_FUNC    = 6'd1;
    localparam logic [ADDR_W-1:0] A_STEP_NS = 6'd2;
    localparam logic [ADDR_W-1:0] A_STEP_FH = 6'd3;
    localparam logic [ADDR_W-1:0] A_STEP_FL = 6'd4;
    localparam logic [ADDR_W-1:0] A_LOAD    = 6'd5;
    localparam logic [ADDR_W-1:0] A_SLOT0   = 6'd12;
    localparam logic [ADDR_W-1:0] A_SLOT1   = 6'd19;
    localparam logic [ADDR_W-1:0] A_STAT    = 6'd26;

    function automatic logic [REG_W-1:0] tod_piece(input tod_t t, input int idx);
        case (idx)
            0:       return t.sec[47:32];
            1:       return t.sec[31:16];
            2:       return t.sec[15:0];
            3:       return t.ns[31:16];
            4:       return t.ns[15:0];
            5:       return t.frac[31:16];
            6:       return t.frac[15:0];
            default: return '0;
        endcase
    endfunction

    function automatic tod_t tod_set(input tod_t t, input int idx, input logic [REG_W-1:0] v);
        tod_t r;
        r = t;
        case (idx)
            0:       r.sec[47:32] = v;
            1:       r.sec[31:16] = v;
            2:       r.sec[15:0]  = v;
            3:       r.ns[31:16]  = v;
            4:       r.ns[15:0]   = v;
            5:       r.frac[31:16] = v;
            6:       r.frac[15:0]  = v;
            default: r = t;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ptp_tod_advance.sv
module ptp_tod_advance
    import ptp_tod_pkg::*;
#(
    parameter int NS_WRAP = 1_000_000_000
) (
    input  tod_t               cur,
    input  logic               run,
    input  logic [REG_W-1:0]   step_ns,
    input  logic [FR_W-1:0]    step_frac,
    input  logic [FR_W-1:0]    trim,
    output tod_t               nxt
);
    localparam int ACC_W = NS_W + FR_W + 2;
    localparam int HI_W  = ACC_W - FR_W;
    localparam logic [HI_W-1:0] WRAP_V = HI_W'(NS_WRAP);

    logic [ACC_W-1:0] step_d;
    logic [ACC_W-1:0] acc_d;
    logic [HI_W-1:0]  hi_d;
    logic             wrap_d;

    always_comb begin
        step_d = {{(ACC_W-REG_W-FR_W){1'b0}}, step_ns, {FR_W{1'b0}}}
               + {{(ACC_W-FR_W){step_frac[FR_W-1]}}, step_frac}
               + {{(ACC_W-FR_W){trim[FR_W-1]}}, trim};
        acc_d  = {2'b00, cur.ns, cur.frac} + step_d;
        hi_d   = acc_d[ACC_W-1:FR_W];
        wrap_d = (hi_d >= WRAP_V);
        if (wrap_d) begin
            hi_d = hi_d - WRAP_V;
        end
        nxt = cur;
        if (run) begin
            nxt.sec  = cur.sec + SEC_W'(wrap_d);
            nxt.ns   = hi_d[NS_W-1:0];
            nxt.frac = acc_d[FR_W-1:0];
        end
    end
endmodule

// File: rtl/ptp_tod_offset.sv
module ptp_tod_offset
    import ptp_tod_pkg::*;
#(
    parameter int NS_WRAP = 1_000_000_000
) (
    input  tod_t a,
    input  tod_t b,
    input  logic sub,
    output tod_t y
);
    localparam int SUM_W = NS_W + FR_W + 1;
    localparam int HI_W  = SUM_W - FR_W;
    localparam logic [HI_W-1:0] WRAP_V = HI_W'(NS_WRAP);

    logic [SUM_W-1:0] sum_d;
    logic [HI_W-1:0]  hi_d;
    logic             cy_d;

    always_comb begin
        if (sub) begin
            sum_d = {1'b0, a.ns, a.frac} - {1'b0, b.ns, b.frac};
            hi_d  = sum_d[SUM_W-1:FR_W];
            cy_d  = sum_d[SUM_W-1];
            if (cy_d) begin
                hi_d = hi_d + WRAP_V;
            end
            y.sec = a.sec - b.sec - SEC_W'(cy_d);
        end else begin
            sum_d = {1'b0, a.ns, a.frac} + {1'b0, b.ns, b.frac};
            hi_d  = sum_d[SUM_W-1:FR_W];
            cy_d  = (hi_d >= WRAP_V);
            if (cy_d) begin
                hi_d = hi_d - WRAP_V;
            end
            y.sec = a.sec + b.sec + SEC_W'(cy_d);
        end
        y.ns   = hi_d[NS_W-1:0];
        y.frac = sum_d[FR_W-1:0];
    end
endmodule

// File: rtl/ptp_tod_capture.sv
module ptp_tod_capture
    import ptp_tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snap,
    input  logic       clr,
    input  tod_t       cur,
    output tod_t       slot0,
    output tod_t       slot1,
    output logic [1:0] vld
);
    typedef struct packed {
        tod_t       s0;
        tod_t       s1;
        logic [1:0] vld;
    } cap_t;

    cap_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d.vld = 2'b00;
        end
        if (snap) begin
            if (!d.vld[0]) begin
                d.s0     = cur;
                d.vld[0] = 1'b1;
            end else begin
                d.s1     = cur;
                d.vld[1] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign slot0 = q.s0;
    assign slot1 = q.s1;
    assign vld   = q.vld;

    // R8: first snapshot lands in slot 0
    a_r8_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (snap && !clr && !q.vld[0]) |=> (q.vld[0] && q.s0 == $past(cur)));
    // R8: later snapshot lands in slot 1
    a_r8_second_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (snap && !clr && q.vld[0]) |=> (q.vld[1] && q.s1 == $past(cur) && $stable(q.s0)));
    // R8: status read clears both bits
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !snap) |=> (q.vld == 2'b00));
endmodule

// File: rtl/ptp_tod_unit.sv
module ptp_tod_unit
    import ptp_tod_pkg::*;
#(
    parameter int NS_WRAP     = 1_000_000_000,
    parameter int RST_STEP_NS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ev_in
);
    typedef struct packed {
        logic             run;
        logic             phase;
        logic [2:0]       func;
        logic [REG_W-1:0] step_ns;
        logic [FR_W-1:0]  step_frac;
        logic [FR_W-1:0]  trim;
        tod_t             load;
        tod_t             cnt;
        logic             ev_prev;
    } st_t;

    st_t d, q;

    logic       trig_sw;
    logic       ev_edge;
    logic       do_op;
    logic [2:0] op;
    tod_t       adv;
    tod_t       ofs;
    tod_t       slot0;
    tod_t       slot1;
    logic [1:0] vld;
    logic [REG_W-1:0] rd16;
    logic       unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:16], reg_wdata[15:9], reg_wdata[7:5], reg_wdata[1]};

    ptp_tod_advance #(.NS_WRAP(NS_WRAP)) u_adv (
        .cur(q.cnt), .run(q.run), .step_ns(q.step_ns),
        .step_frac(q.step_frac), .trim(q.trim), .nxt(adv)
    );

    ptp_tod_offset #(.NS_WRAP(NS_WRAP)) u_ofs (
        .a(adv), .b(q.load), .sub(op == FN_SUB), .y(ofs)
    );

    ptp_tod_capture u_cap (
        .clk(clk), .rst_n(rst_n),
        .snap(do_op && op == FN_SNAP),
        .clr(reg_rd && reg_addr == A_STAT),
        .cur(q.cnt), .slot0(slot0), .slot1(slot1), .vld(vld)
    );

    always_comb begin
        d       = q;
        trig_sw = reg_wr && (reg_addr == A_FUNC) && reg_wdata[0];
        ev_edge = ev_in && !q.ev_prev;
        do_op   = trig_sw || ev_edge;
        op      = trig_sw ? reg_wdata[4:2] : q.func;
        d.ev_prev = ev_in;
        if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                d.run = reg_wdata[0];
            end else if (reg_addr == A_FUNC) begin
                d.func  = reg_wdata[4:2];
                d.phase = reg_wdata[8];
            end else if (reg_addr == A_STEP_NS) begin
                d.step_ns = reg_wdata[15:0];
            end else if (reg_addr == A_STEP_FH) begin
                d.step_frac[31:16] = reg_wdata[15:0];
            end else if (reg_addr == A_STEP_FL) begin
                d.step_frac[15:0] = reg_wdata[15:0];
            end else if (reg_addr >= A_LOAD && reg_addr < A_SLOT0) begin
                d.load = tod_set(q.load, int'(reg_addr - A_LOAD), reg_wdata[15:0]);
            end
        end
        d.cnt = adv;
        if (do_op) begin
            case (op)
                FN_LOAD:        d.cnt  = q.load;
                FN_ADD, FN_SUB: d.cnt  = ofs;
                FN_TRIM:        d.trim = q.load.frac;
                default:        ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.func    <= FN_IDLE;
            q.step_ns <= REG_W'(RST_STEP_NS);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd16 = '0;
        if (reg_addr == A_CTRL)
            rd16 = {15'b0, q.run};
        else if (reg_addr == A_FUNC)
            rd16 = {7'b0, q.phase, 3'b0, q.func, 2'b0};
        else if (reg_addr == A_STEP_NS)
            rd16 = q.step_ns;
        else if (reg_addr == A_STEP_FH)
            rd16 = q.step_frac[31:16];
        else if (reg_addr == A_STEP_FL)
            rd16 = q.step_frac[15:0];
        else if (reg_addr >= A_LOAD && reg_addr < A_SLOT0)
            rd16 = tod_piece(q.load, int'(reg_addr - A_LOAD));
        else if (reg_addr >= A_SLOT0 && reg_addr < A_SLOT1)
            rd16 = tod_piece(slot0, int'(reg_addr - A_SLOT0));
        else if (reg_addr >= A_SLOT1 && reg_addr < A_STAT)
            rd16 = tod_piece(slot1, int'(reg_addr - A_SLOT1));
        else if (reg_addr == A_STAT)
            rd16 = {14'b0, vld};
    end

    assign reg_rdata = {16'b0, rd16};

    // R2: with the run bit clear and no command, time holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.run && !do_op) |=> $stable(q.cnt));
    // R3: nanoseconds stay in range across steps
    a_r3_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt.ns < NS_W'(NS_WRAP) && !do_op) |=> (q.cnt.ns < NS_W'(NS_WRAP)));
    // R5: load copies the staged time
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (do_op && op == FN_LOAD) |=> (q.cnt == $past(q.load)));
    // R7: trim takes the staged fraction
    a_r7_trim: assert property (@(posedge clk) disable iff (!rst_n)
        (do_op && op == FN_TRIM) |=> (q.trim == $past(q.load.frac)));
    // R9: a sampled rising edge of the event runs a command
    a_r9_event_runs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_in) |-> do_op);
endmodule

// File: tb/test_ptp_tod_unit.sv
module test_ptp_tod_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] WRAP = 128'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd, ev_in;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0]  v;
    logic [111:0] t, ta, tb, tc;

    ptp_tod_unit i_ptp_tod_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_in(ev_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] to_u(input logic [111:0] f);
        return ((128'(f[111:64]) * WRAP + 128'(f[63:32])) << 32) + 128'(f[31:0]);
    endfunction

    function automatic logic [111:0] fields(input logic [127:0] u);
        logic [127:0] per, s, r;
        per = WRAP << 32;
        s = u / per;
        r = u % per;
        return {s[47:0], r[63:32], r[31:0]};
    endfunction

    task automatic check(input string tag, input logic [111:0] act, input logic [111:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] dv);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = dv;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] dv);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 dv = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic fire(input logic [2:0] code);
        wr(6'd1, {23'b0, 1'b0, 3'b0, code, 2'b01});
    endtask

    task automatic stage(input logic [111:0] f);
        for (int i = 0; i < 7; i++)
            wr(6'd5 + 6'(i), {16'b0, f[111 - 16*i -: 16]});
    endtask

    task automatic rd_slot(input logic [5:0] base, output logic [111:0] f);
        logic [31:0] p;
        for (int i = 0; i < 7; i++) begin
            rd(base + 6'(i), p);
            f[111 - 16*i -: 16] = p[15:0];
        end
    endtask

    task automatic pulse_ev(input int len);
        @(negedge clk); ev_in = 1'b1;
        repeat (len) @(negedge clk);
        ev_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] bns [4] = '{32'd0, 32'd1, 32'd499_999_999, 32'd999_999_999};
        logic [31:0] bfr [2] = '{32'h0, 32'hFFFF_FFFF};
        logic [31:0] ons [4] = '{32'd0, 32'd1, 32'd500_000_000, 32'd999_999_999};
        logic [31:0] ofr [3] = '{32'h0, 32'h1, 32'hFFFF_FFFF};
        logic [15:0] sns [3] = '{16'd1, 16'd3, 16'd7};
        logic [31:0] sfr [3] = '{32'h0, 32'h4000_0000, 32'hC000_0000};
        logic [31:0] trm [3] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000};
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; ev_in = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'd2, v);  check("R1 step_ns", 112'(v), 112'd3);
        rd(6'd3, v);  check("R1 step_frac_hi", 112'(v), 112'd0);
        rd(6'd1, v);  check("R1 command", 112'(v), 112'h1C);
        rd(6'd0, v);  check("R1 run", 112'(v), 112'd0);
        rd(6'd26, v); check("R1 status", 112'(v), 112'd0);

        // R10 upper write bits ignored, upper read bits zero
        wr(6'd3, 32'hFFFF_1234);
        rd(6'd3, v); check("R10 width", 112'(v), 112'h1234);
        wr(6'd3, 32'h0);

        // R5 load then R8 snapshot
        ta = {48'h1234_5678_9ABC, 32'd999_999_999, 32'hDEAD_BEEF};
        stage(ta); fire(3'd0); fire(3'd4);
        rd(6'd26, v); check("R8 status slot0", 112'(v), 112'd1);
        rd_slot(6'd12, t); check("R5 load", t, ta);
        rd(6'd26, v); check("R8 status cleared", 112'(v), 112'd0);

        // R2 frozen while run bit clear
        repeat (20) @(negedge clk);
        fire(3'd4); rd(6'd26, v);
        rd_slot(6'd12, t); check("R2 frozen", t, ta);

        // R6 add/subtract sweep
        for (int op = 2; op <= 3; op++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 2; j++)
                    for (int k = 0; k < 4; k++)
                        for (int m = 0; m < 3; m++) begin
                            ta = {48'd1000, bns[i], bfr[j]};
                            tb = {48'd7, ons[k], ofr[m]};
                            stage(ta); fire(3'd0);
                            stage(tb); fire(3'(op));
                            fire(3'd4); rd(6'd26, v);
                            rd_slot(6'd12, t);
                            tc = (op == 2) ? fields(to_u(ta) + to_u(tb))
                                           : fields(to_u(ta) - to_u(tb));
                            check(op == 2 ? "R6 add" : "R6 subtract", t, tc);
                        end

        // R2 R3 R7 advance sweep across a second boundary
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                for (int k = 0; k < 3; k++) begin
                    automatic int kk = 2 + i + j + k;
                    automatic longint st;
                    wr(6'd2, {16'b0, sns[i]});
                    wr(6'd3, {16'b0, sfr[j][31:16]});
                    wr(6'd4, {16'b0, sfr[j][15:0]});
                    stage({48'd0, 32'd0, trm[k]}); fire(3'd1);
                    ta = {48'd5, 32'd999_999_990, 32'hF000_0000};
                    stage(ta); fire(3'd0);
                    wr(6'd0, 32'd1);
                    repeat (kk) @(negedge clk);
                    fire(3'd4);
                    wr(6'd0, 32'd0);
                    rd(6'd26, v);
                    rd_slot(6'd12, t);
                    st = (longint'(sns[i]) <<< 32) + longint'($signed(sfr[j]))
                       + longint'($signed(trm[k]));
                    tc = fields(to_u(ta) + 128'(st) * 128'(kk + 1));
                    check("R2 R3 R7 advance", t, tc);
                end

        // R8 slot order
        ta = {48'd11, 32'd1, 32'd2};
        tb = {48'd22, 32'd3, 32'd4};
        tc = {48'd33, 32'd5, 32'd6};
        stage(ta); fire(3'd0); fire(3'd4);
        stage(tb); fire(3'd0); fire(3'd4);
        stage(tc); fire(3'd0); fire(3'd4);
        rd(6'd26, v); check("R8 both valid", 112'(v), 112'd3);
        rd_slot(6'd12, t); check("R8 slot0 first", t, ta);
        rd_slot(6'd19, t); check("R8 slot1 last", t, tc);

        // R4 select without firing, readback of fields
        ta = {48'hA, 32'd123, 32'd456};
        stage(ta); fire(3'd0);
        rd(6'd26, v);
        wr(6'd1, 32'h0000_0110);
        rd(6'd1, v); check("R4 command readback", 112'(v), 112'h110);
        rd(6'd26, v); check("R4 select only", 112'(v), 112'd0);

        // R9 held event runs the stored snapshot once
        pulse_ev(5);
        rd(6'd26, v); check("R9 single action", 112'(v), 112'd1);
        rd_slot(6'd12, t); check("R9 event snapshot", t, ta);

        // R9 code 7 has no effect
        wr(6'd1, 32'h0000_001C);
        pulse_ev(2);
        rd(6'd26, v); check("R9 idle code", 112'(v), 112'd0);
        fire(3'd4); rd(6'd26, v);
        rd_slot(6'd12, t); check("R9 idle keeps time", t, ta);

        // R9 event runs a stored load
        tb = {48'hB, 32'd777, 32'd888};
        stage(tb);
        wr(6'd1, 32'h0000_0000);
        pulse_ev(1);
        fire(3'd4); rd(6'd26, v);
        rd_slot(6'd12, t); check("R9 event load", t, tb);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule